// File: doc/BRIEF.md
# Two-Way Steering Interrupt Controller

This block gathers level-sensitive interrupt requests from on-chip units into one 32-bit request vector. Each request that software has enabled goes to one of two processor interrupt lines: a normal line (IRQ) or a fast line (FIQ). Only 22 positions in the vector carry real sources. These are bits 31 down to 17 and bits 14 down to 8. Bits 16, 15 and 7 through 0 are never sources.

Software reaches the block through a small word-addressed register port with 32-bit data. Two registers are writable. The enable register turns sources on or off. The routing register picks the destination of each source: a 0 sends it to IRQ and a 1 sends it to FIQ. Software can read three pending views: IRQ, FIQ and the union of the two. None of the pending bits is stored. Each one follows its request line live, so a pending bit clears only when the unit that raised the request drops it. The two processor outputs are registered copies of "any IRQ pending" and "any FIQ pending".

Top module: `irq_steer_ctrl`

## Requirements
- R1: Only positions 8–14 and 17–31 (mask 0xFFFE7F00) are sources. The enable register (offset 0x4) and the routing register (offset 0x8) store written data ANDed with 0xFFFE7F00. Their other bits always read 0, and so do pending bits 7:0, 15 and 16.
- R2: The IRQ pending view at offset 0x0 reads request AND enable AND NOT routing, on source positions only.
- R3: The FIQ pending view at offset 0xC reads request AND enable AND routing, on source positions only.
- R4: The combined view at offset 0x10 reads the bitwise OR of the IRQ and FIQ views. No bit is ever set in both the IRQ and FIQ views.
- R5: Writes to offsets 0x0, 0xC and 0x10 change neither the enable register nor the routing register.
- R6: After reset the enable and routing registers are 0, every pending view reads 0, and both interrupt outputs are 0.
- R7: `irqOut` and `fiqOut` equal the OR of the IRQ pending bits and the OR of the FIQ pending bits, one clock edge later.
- R8: Reads of any other offset return 0, and writes to such offsets change no register.
- R9: A pending bit has no storage. It clears in the same cycle the request drops, with no write from software.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 5 | Byte offset of the register access |
| busWrite | input | 1 | Write strobe, captured at the clock edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr` (combinational) |
| srcReq | input | 32 | Level-sensitive request lines, one per bit |
| irqOut | output | 1 | Normal interrupt to the processor, active high |
| fiqOut | output | 1 | Fast interrupt to the processor, active high |

## Verification
Several properties are checked on every cycle:
- Bits outside the 22 source positions stay 0 in the enable and routing registers.
- No request appears in both the IRQ and FIQ views.
- Each output equals the previous cycle's OR of its view.
- The enable and routing registers hold still whenever their write strobes are idle.
- The decoder never raises both write strobes at once.

Other behaviour can only be shown by the bench's scenarios. This covers the decoded values of each view for a given mix of requests, enables and routing, and the register offsets themselves. It also covers a pending bit dropping as soon as its request falls, and writes to read-only and unmapped offsets leaving the state untouched.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int DATA_W = 32;
  localparam logic [DATA_W-1:0] SRC_POS = 32'hFFFE_7F00;

  typedef enum logic [2:0] {
    SEL_IRQ, SEL_EN, SEL_ROUTE, SEL_FIQ, SEL_ANY, SEL_NONE
  } readSel_e;

  typedef struct packed {
    logic     wrEnable;
    logic     wrRoute;
    readSel_e rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_steer_decode.sv
module irq_steer_decode
  import irq_steer_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  output ctrlStrobe_t       strobe
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic              aligned;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    strobe.wrEnable = 1'b0;
    strobe.wrRoute  = 1'b0;
    strobe.rdSel    = SEL_NONE;
    if (aligned) begin
      case (wordIdx)
        WORD_W'(0): strobe.rdSel = SEL_IRQ;
        WORD_W'(1): begin
          strobe.rdSel    = SEL_EN;
          strobe.wrEnable = busWrite;
        end
        WORD_W'(2): begin
          strobe.rdSel   = SEL_ROUTE;
          strobe.wrRoute = busWrite;
        end
        WORD_W'(3): strobe.rdSel = SEL_FIQ;
        WORD_W'(4): strobe.rdSel = SEL_ANY;
        default:    strobe.rdSel = SEL_NONE;
      endcase
    end
  end

  // R5/R8: at most one register is written per access, and only on a bus write
  p_one_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrEnable, strobe.wrRoute}));
  p_write_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busWrite |-> !(strobe.wrEnable || strobe.wrRoute));
endmodule

// File: rtl/irq_steer_datapath.sv
module irq_steer_datapath
  import irq_steer_pkg::*;
#(
  parameter int              NUM_BITS = DATA_W,
  parameter logic [NUM_BITS-1:0] SRC_MAP = SRC_POS
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [NUM_BITS-1:0] busWdata,
  input  logic [NUM_BITS-1:0] srcReq,
  output logic [NUM_BITS-1:0] busRdata,
  output logic                irqOut,
  output logic                fiqOut
);
  logic [NUM_BITS-1:0] enableReg, routeReg;
  logic [NUM_BITS-1:0] irqPend, fiqPend, anyPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableReg <= '0;
      routeReg  <= '0;
    end else begin
      if (strobe.wrEnable) enableReg <= busWdata & SRC_MAP;
      if (strobe.wrRoute)  routeReg  <= busWdata & SRC_MAP;
    end
  end

  // Per-position steering: only source positions get logic
  for (genvar b = 0; b < NUM_BITS; b++) begin : g_bit
    if (SRC_MAP[b]) begin : g_src
      logic live;
      assign live       = srcReq[b] & enableReg[b];
      assign irqPend[b] = live & ~routeReg[b];
      assign fiqPend[b] = live &  routeReg[b];
    end else begin : g_rsv
      assign irqPend[b] = 1'b0;
      assign fiqPend[b] = 1'b0;
    end
  end

  assign anyPend = irqPend | fiqPend;

  always_comb begin
    unique case (strobe.rdSel)
      SEL_IRQ:   busRdata = irqPend;
      SEL_EN:    busRdata = enableReg;
      SEL_ROUTE: busRdata = routeReg;
      SEL_FIQ:   busRdata = fiqPend;
      SEL_ANY:   busRdata = anyPend;
      default:   busRdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut <= 1'b0;
      fiqOut <= 1'b0;
    end else begin
      irqOut <= |irqPend;
      fiqOut <= |fiqPend;
    end
  end

  p_rsv_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    ((enableReg | routeReg) & ~SRC_MAP) == '0);
  p_disjoint_r4: assert property (@(posedge clk) disable iff (!rstN)
    (irqPend & fiqPend) == '0);
  p_irq_lag_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == $past(|irqPend));
  p_fiq_lag_r7: assert property (@(posedge clk) disable iff (!rstN)
    fiqOut == $past(|fiqPend));
  p_hold_en_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEnable |=> $stable(enableReg));
  p_hold_route_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrRoute |=> $stable(routeReg));
endmodule

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl
  import irq_steer_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [31:0]       srcReq,
  output logic              irqOut,
  output logic              fiqOut
);
  ctrlStrobe_t strobe;

  irq_steer_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWrite (busWrite),
    .strobe   (strobe)
  );

  irq_steer_datapath #(.NUM_BITS(DATA_W), .SRC_MAP(SRC_POS)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .srcReq   (srcReq),
    .busRdata (busRdata),
    .irqOut   (irqOut),
    .fiqOut   (fiqOut)
  );
endmodule

// File: tb/irq_steer_ctrl_tb.sv
module irq_steer_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] srcReq = '0;
  logic        irqOut, fiqOut;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  irq_steer_ctrl u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .srcReq(srcReq),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );

  // {request, enable, routing, expected IRQ view, expected FIQ view}
  localparam logic [4:0][31:0] VEC [7] = '{
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFE_7F00, 32'h0000_0000},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFE_7F00},
    '{32'h0000_FF00, 32'hFFFF_FFFF, 32'h0000_F000, 32'h0000_0F00, 32'h0000_7000},
    '{32'hFFFF_0000, 32'h00FF_0000, 32'h00AA_0000, 32'h0054_0000, 32'h00AA_0000},
    '{32'h0000_00FF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
    '{32'h8000_0100, 32'h8000_0100, 32'h8000_0000, 32'h0000_0100, 32'h8000_0000},
    '{32'h0001_8000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    srcReq = 32'hFFFF_FFFF;
    rd(5'h00, v); check("R6 irq view in reset", v, 0);
    rstN = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(5'h04, v); check("R6 enable reset", v, 0);
    rd(5'h08, v); check("R6 routing reset", v, 0);
    rd(5'h10, v); check("R6 combined view reset", v, 0);
    check("R6 outputs reset", {30'd0, irqOut, fiqOut}, 0);

    // Table walk: R2, R3, R4, R7
    for (int i = 0; i < 7; i++) begin
      wr(5'h04, VEC[i][3]);
      wr(5'h08, VEC[i][2]);
      srcReq = VEC[i][4];
      rd(5'h00, v); check("R2 irq view", v, VEC[i][1]);
      rd(5'h0C, v); check("R3 fiq view", v, VEC[i][0]);
      rd(5'h10, v); check("R4 combined view", v, VEC[i][1] | VEC[i][0]);
      @(negedge clk);
      check("R7 irqOut", {31'd0, irqOut}, {31'd0, VEC[i][1] != 0});
      check("R7 fiqOut", {31'd0, fiqOut}, {31'd0, VEC[i][0] != 0});
    end

    // R1: reserved positions cannot be stored
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, v); check("R1 enable readback", v, 32'hFFFE_7F00);
    wr(5'h08, 32'h0001_80FF);
    rd(5'h08, v); check("R1 routing readback", v, 0);

    // R5: writes to the pending views change nothing
    wr(5'h00, 32'h0);
    wr(5'h0C, 32'h0);
    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h04, v); check("R5 enable untouched", v, 32'hFFFE_7F00);
    rd(5'h08, v); check("R5 routing untouched", v, 0);

    // R8: unmapped offsets
    rd(5'h14, v); check("R8 unmapped read", v, 0);
    rd(5'h1C, v); check("R8 unmapped read high", v, 0);
    rd(5'h06, v); check("R8 misaligned read", v, 0);
    wr(5'h18, 32'h0);
    wr(5'h05, 32'h0);
    rd(5'h04, v); check("R8 enable after unmapped write", v, 32'hFFFE_7F00);

    // R9: pending follows the request with no storage
    wr(5'h08, 32'h0010_0000);
    srcReq = 32'h0010_0200;
    rd(5'h00, v); check("R9 irq set", v, 32'h0000_0200);
    rd(5'h0C, v); check("R9 fiq set", v, 32'h0010_0000);
    srcReq = 32'h0010_0000;
    rd(5'h00, v); check("R9 irq cleared by source", v, 0);
    @(negedge clk);
    check("R9 irqOut drops", {31'd0, irqOut}, 0);
    check("R9 fiqOut stays", {31'd0, fiqOut}, 1);
    srcReq = 32'h0;
    rd(5'h10, v); check("R9 all cleared", v, 0);
    @(negedge clk);
    check("R9 fiqOut drops", {31'd0, fiqOut}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule